// File: doc/BRIEF.md
# General-Purpose I/O Port Controller with Address-Masked Access

This block is an eight-pin general-purpose I/O port controller. Software reaches it through a simple synchronous register bus. Each access carries a 12-bit byte offset. Writes carry 32 bits of data, and every register holds 8 effective bits.

Data register access works through a window of offsets. In that window, address bits [9:2] act as a per-bit mask. Software can therefore read or change single pins without a read-modify-write sequence. A direction register selects which pins the port drives. An undriven pin resolves high at the output. An input pin's data bit follows its external level, taken through a synchronizer.

Each input pin can raise an interrupt on a level, a single edge or both edges. These interrupts are gathered into raw and masked status and one interrupt line. The block also provides:
- eight plain pad-control storage registers;
- a key-protected lock that guards a commit register, which in turn decides which alternate-function select bits may change;
- a read-only identification window.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset, direction, configuration, status, alternate-function and pad registers read zero. Every resolved pin level is 1 and the interrupt output is 0. The lock register (0x520) reads 1 and the commit register (0x524) reads 0xFF.
- R2: A read at an offset below 0x400 returns the data register ANDed with address bits [9:2]. Read data appears on the bus the cycle after the read strobe.
- R3: A write at an offset below 0x400 changes only data bits that are set in address bits [9:2] and marked as outputs. All other data bits keep their value.
- R4: The direction register (0x400) marks a pin as output with a 1. The resolved pin level is (data AND direction) OR NOT direction.
- R5: Each input pin's data bit takes the external level after a two-stage synchronizer, within three clock edges. For output pins the external level is ignored.
- R6: Writing exactly 0x0ACCE551 to the lock register unlocks the port, and it then reads 0. Any other value written there relocks it, and it then reads 1.
- R7: The commit register accepts writes only while the port is unlocked.
- R8: A write to the alternate-function select register (0x420) updates only the bits whose commit bit is 1.
- R9: When a pin's sense bit (0x404) is 0, its raw status bit (0x414) is set on an edge of the input. With the both-edges bit (0x408) set, either edge counts. Otherwise the event bit (0x40C) picks the edge: 1 for rising, 0 for falling.
- R10: When a pin's sense bit is 1, its raw status bit is set while the input level equals the event bit. Writing to 0x41C clears each raw bit where the written value has a 1, but a bit whose condition still holds stays set.
- R11: The masked status (0x418) reads raw status AND the mask register (0x410). The interrupt output is the OR of the masked bits.
- R12: Reads in 0xFD0..0xFFC return identification bytes indexed by (offset-0xFD0)/4. In index order they are 00,00,00,00,61,00,18,01,0D,F0,05,B1.
- R13: The eight pad-control registers at 0x500..0x51C (step 4) are plain read/write storage. Undefined offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; data returned next cycle |
| addr | input | 12 | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Resolved pin levels |
| irq | output | 1 | Combined masked interrupt |

## Verification
The masked data window is exercised with full, single-bit, two-bit and empty address masks. The direction register makes half the pins inputs. These patterns separate a correct mask-AND-direction gate from one that ignores either term, and from a read path that forgets the mask.

Interrupt detection runs with these per-pin settings, so that each mode is seen in isolation:

| Pin | Mode |
|---|---|
| bit0 | rising edge |
| bit1 | falling edge |
| bit2 | both edges |
| bit3 | high level |

Going the opposite way on bit0 and bit1 shows that polarity is honoured. Clearing bit3 while its level persists shows that a set condition wins over clear.

// File: rtl/gpio_pkg.sv
// Package: word offsets (byte offset >> 2), unlock key and identification
// bytes shared by the port controller and its submodules.
package gpio_pkg;
    localparam logic [9:0] W_DIR     = 10'h100;
    localparam logic [9:0] W_SENSE   = 10'h101;
    localparam logic [9:0] W_BOTH    = 10'h102;
    localparam logic [9:0] W_EVT     = 10'h103;
    localparam logic [9:0] W_IMASK   = 10'h104;
    localparam logic [9:0] W_RAW     = 10'h105;
    localparam logic [9:0] W_MASKED  = 10'h106;
    localparam logic [9:0] W_CLEAR   = 10'h107;
    localparam logic [9:0] W_ALTFN   = 10'h108;
    localparam logic [9:0] W_PAD0    = 10'h140;
    localparam logic [9:0] W_LOCK    = 10'h148;
    localparam logic [9:0] W_COMMIT  = 10'h149;
    localparam logic [9:0] W_ID0     = 10'h3F4;
    localparam int         PAD_REGS  = 8;
    localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

    // Identification byte for index 0..11; other indices give zero.
    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd4:    return 8'h61;
            4'd6:    return 8'h18;
            4'd7:    return 8'h01;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes STAGES >= 1; output lags the pin by STAGES clock edges; resets low.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pin level one stage further each clock.
            always_ff @(posedge clk) begin
                if (!rst_n)     stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= async_in;
                else            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_key_lock.sv
// Key-protected lock and commit register.
// Assumes lock_wr/commit_wr are single-cycle decoded write strobes.
// Resets locked with every commit bit set.
module gpio_key_lock #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_wr,
    input  logic             commit_wr,
    input  logic [31:0]      wr_data,
    output logic             locked,
    output logic [NPINS-1:0] commit
);
    import gpio_pkg::*;

    // Lock flag: only the exact key opens it, anything else closes it.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked <= 1'b1;
        else if (lock_wr) locked <= (wr_data != UNLOCK_KEY);
    end

    // Commit register: writable only while open.
    always_ff @(posedge clk) begin
        if (!rst_n)                    commit <= '1;
        else if (commit_wr && !locked) commit <= wr_data[NPINS-1:0];
    end

    a_r6_relock_on_wrong_key: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wr_data != UNLOCK_KEY) |=> locked);
    a_r7_commit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr && locked) |=> $stable(commit));
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin interrupt detection: level or edge (single or both) on the
// synchronized input, collected into sticky raw status bits.
// Assumes level_in is already synchronized; only input pins (dir=0) set bits.
// A set condition in the same cycle as a clear wins.
module gpio_irq_detect #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] level_in,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] sense,
    input  logic [NPINS-1:0] both,
    input  logic [NPINS-1:0] evt,
    input  logic             clr_wr,
    input  logic [NPINS-1:0] clr_bits,
    output logic [NPINS-1:0] raw
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] edge_hit, level_hit, set_bits, clr_eff;

    // Decode the per-pin trigger condition from the configuration.
    always_comb begin
        edge_hit  = (both & (level_in ^ prev_q))
                  | (~both &  evt &  level_in & ~prev_q)
                  | (~both & ~evt & ~level_in &  prev_q);
        level_hit = ~(level_in ^ evt);
        set_bits  = ~dir & ((sense & level_hit) | (~sense & edge_hit));
        clr_eff   = clr_wr ? clr_bits : '0;
    end

    // Previous level for edge detection, and sticky status update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            raw    <= '0;
        end else begin
            prev_q <= level_in;
            raw    <= (raw & ~clr_eff) | set_bits;
        end
    end

    a_r9_new_status_only_on_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & ~$past(raw) & $past(dir)) == '0);
endmodule

// File: rtl/gpio_port_ctl.sv
// Eight-pin GPIO port controller with address-masked data access,
// direction control, interrupt configuration/status, pad storage,
// key-guarded alternate-function select and an identification window.
// Assumes NPINS <= 8 (mask taken from address bits [2 +: NPINS]);
// bit [1:0] of the offset is ignored; read data is registered.
module gpio_port_ctl #(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [11:0]      addr,
    input  logic [31:0]      wr_data,
    output logic [NPINS-1:0] rd_data,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic             irq
);
    import gpio_pkg::*;

    localparam int PAD_SEL_W = $clog2(PAD_REGS);

    logic [9:0]       word;
    logic             in_data_win, in_pad_win, in_id_win;
    logic [NPINS-1:0] addr_mask, wr_mask, wbits;
    logic [NPINS-1:0] data_q, dir_q, sense_q, both_q, evt_q, imask_q, altfn_q;
    logic [NPINS-1:0] pad_q [PAD_REGS];
    logic [NPINS-1:0] level_s, raw_st, commit;
    logic             locked;
    logic [NPINS-1:0] rd_mux;

    assign word        = addr[11:2];
    assign in_data_win = (addr[11:10] == 2'b00);
    assign in_pad_win  = (word[9:PAD_SEL_W] == W_PAD0[9:PAD_SEL_W]);
    assign in_id_win   = (word >= W_ID0);
    assign addr_mask   = addr[2 +: NPINS];
    assign wr_mask     = (wr_en && in_data_win) ? addr_mask : '0;
    assign wbits       = wr_data[NPINS-1:0];

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(level_s));

    gpio_key_lock #(.NPINS(NPINS)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .lock_wr(wr_en && word == W_LOCK),
        .commit_wr(wr_en && word == W_COMMIT),
        .wr_data(wr_data), .locked(locked), .commit(commit));

    gpio_irq_detect #(.NPINS(NPINS)) u_irq (
        .clk(clk), .rst_n(rst_n), .level_in(level_s), .dir(dir_q),
        .sense(sense_q), .both(both_q), .evt(evt_q),
        .clr_wr(wr_en && word == W_CLEAR), .clr_bits(wbits), .raw(raw_st));

    generate
        for (genvar b = 0; b < NPINS; b++) begin : g_data
            // Data bit: masked write for outputs, synchronized level for inputs.
            always_ff @(posedge clk) begin
                if (!rst_n)          data_q[b] <= 1'b0;
                else if (!dir_q[b])  data_q[b] <= level_s[b];
                else if (wr_mask[b]) data_q[b] <= wbits[b];
            end
        end
        for (genvar p = 0; p < PAD_REGS; p++) begin : g_pad
            // Pad-control storage register p.
            always_ff @(posedge clk) begin
                if (!rst_n) pad_q[p] <= '0;
                else if (wr_en && in_pad_win && word[PAD_SEL_W-1:0] == PAD_SEL_W'(p))
                    pad_q[p] <= wbits;
            end
        end
    endgenerate

    // Direction and interrupt configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0; sense_q <= '0; both_q <= '0; evt_q <= '0; imask_q <= '0;
        end else if (wr_en) begin
            case (word)
                W_DIR:   dir_q   <= wbits;
                W_SENSE: sense_q <= wbits;
                W_BOTH:  both_q  <= wbits;
                W_EVT:   evt_q   <= wbits;
                W_IMASK: imask_q <= wbits;
                default: ;
            endcase
        end
    end

    // Alternate-function select, gated bit by bit by the commit register.
    always_ff @(posedge clk) begin
        if (!rst_n)                      altfn_q <= '0;
        else if (wr_en && word == W_ALTFN) altfn_q <= (altfn_q & ~commit) | (wbits & commit);
    end

    // Read multiplexer over all windows and registers.
    always_comb begin
        rd_mux = '0;
        if (in_data_win)     rd_mux = data_q & addr_mask;
        else if (in_pad_win) rd_mux = pad_q[word[PAD_SEL_W-1:0]];
        else if (in_id_win)  rd_mux = NPINS'(id_byte(word[3:0] - 4'd4));
        else begin
            case (word)
                W_DIR:    rd_mux = dir_q;
                W_SENSE:  rd_mux = sense_q;
                W_BOTH:   rd_mux = both_q;
                W_EVT:    rd_mux = evt_q;
                W_IMASK:  rd_mux = imask_q;
                W_RAW:    rd_mux = raw_st;
                W_MASKED: rd_mux = raw_st & imask_q;
                W_ALTFN:  rd_mux = altfn_q;
                W_LOCK:   rd_mux = NPINS'(locked);
                W_COMMIT: rd_mux = commit;
                default:  rd_mux = '0;
            endcase
        end
    end

    // Registered read data, updated on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign pin_out = (data_q & dir_q) | ~dir_q;
    assign irq     = |(raw_st & imask_q);

    a_r3_unmasked_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(wr_mask)) == '0);
    a_r8_altfn_uncommitted_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((altfn_q ^ $past(altfn_q)) & ~$past(commit)) == '0);
    a_r11_irq_low_without_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_q == '0) |-> !irq);
endmodule

// File: tb/gpio_port_ctl_test.sv
module gpio_port_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_data, pin_in = '0, pin_out;
    logic        irq;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    gpio_port_ctl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .irq(irq));

    always #2.5 clk = ~clk;

    // Data-window vectors: {is_write, offset, write data, expected read}.
    // Direction is 0xF0 and inputs are low while these run.
    localparam logic [28:0] VEC [0:9] = '{
        {1'b1, 12'h3FC, 8'hFF, 8'h00},  // R3 all-ones mask: only outputs change
        {1'b0, 12'h3FC, 8'h00, 8'hF0},  // R3
        {1'b0, 12'h0C0, 8'h00, 8'h30},  // R2 two-bit mask
        {1'b1, 12'h200, 8'h00, 8'h00},  // R3 single-bit mask clears bit7
        {1'b0, 12'h3FC, 8'h00, 8'h70},
        {1'b1, 12'h180, 8'h00, 8'h00},  // R3 mask 0x60 clears bits 6,5
        {1'b0, 12'h3FC, 8'h00, 8'h10},
        {1'b0, 12'h000, 8'h00, 8'h00},  // R2 empty mask reads zero
        {1'b1, 12'h000, 8'hFF, 8'h00},  // R3 empty mask writes nothing
        {1'b0, 12'h3FC, 8'h00, 8'h10}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_out", pin_out, 8'hFF);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd_chk("R1 lock", 12'h520, 8'h01);
        rd_chk("R1 commit", 12'h524, 8'hFF);
        rd_chk("R1 dir", 12'h400, 8'h00);
        rd_chk("R1 raw", 12'h414, 8'h00);

        // R4 direction: upper nibble outputs
        wr(12'h400, 32'hF0);
        rd_chk("R4 dir", 12'h400, 8'hF0);
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][28]) wr(VEC[i][27:16], {24'd0, VEC[i][15:8]});
            else            rd_chk("R2/R3 vector", VEC[i][27:16], VEC[i][7:0]);
        end
        check("R4 pin_out", pin_out, 8'h1F);

        // R5 inputs follow pins, outputs ignore them
        pin_in = 8'h0A; settle();
        rd_chk("R5 input copy", 12'h3FC, 8'h1A);
        pin_in = 8'hFA; settle();
        rd_chk("R5 output ignores pin", 12'h3FC, 8'h1A);
        check("R5 pin_out unaffected", pin_out, 8'h1F);

        // R6/R7/R8 lock, commit and alternate function
        wr(12'h420, 32'h5A);
        rd_chk("R8 full commit", 12'h420, 8'h5A);
        wr(12'h524, 32'h0F);
        rd_chk("R7 locked commit", 12'h524, 8'hFF);
        wr(12'h520, 32'h0ACCE551);
        rd_chk("R6 unlocked", 12'h520, 8'h00);
        wr(12'h524, 32'h0F);
        rd_chk("R7 unlocked commit", 12'h524, 8'h0F);
        wr(12'h520, 32'h0ACCE550);
        rd_chk("R6 relocked", 12'h520, 8'h01);
        wr(12'h524, 32'hFF);
        rd_chk("R7 commit frozen", 12'h524, 8'h0F);
        wr(12'h420, 32'hA5);
        rd_chk("R8 partial commit", 12'h420, 8'h55);

        // R12 identification window
        rd_chk("R12 id0", 12'hFD0, 8'h00);
        rd_chk("R12 id4", 12'hFE0, 8'h61);
        rd_chk("R12 id8", 12'hFF0, 8'h0D);
        rd_chk("R12 id11", 12'hFFC, 8'hB1);

        // R13 pad storage and undefined offsets
        wr(12'h514, 32'h3C);
        rd_chk("R13 pad write", 12'h514, 8'h3C);
        rd_chk("R13 other pad", 12'h500, 8'h00);
        wr(12'h800, 32'hFF);
        rd_chk("R13 undefined read", 12'h800, 8'h00);
        rd_chk("R13 undefined write ignored", 12'h400, 8'hF0);
        rd_chk("R13 clear offset reads zero", 12'h41C, 8'h00);

        // R9 edges: bit0 rising, bit1 falling, bit2 both, bit3 high level
        pin_in = 8'h02; settle();
        wr(12'h40C, 32'h09);
        wr(12'h408, 32'h04);
        wr(12'h404, 32'h08);
        wr(12'h41C, 32'hFF);
        rd_chk("R9 idle raw", 12'h414, 8'h00);
        pin_in = 8'h05; settle();   // bit0 up, bit1 down, bit2 up
        rd_chk("R9 rise/fall/both", 12'h414, 8'h07);
        wr(12'h41C, 32'hFF);
        pin_in = 8'h02; settle();   // bit0 down, bit1 up, bit2 down
        rd_chk("R9 opposite edges", 12'h414, 8'h04);
        wr(12'h41C, 32'hFF);

        // R10 level sense and clear
        pin_in = 8'h0A; settle();
        rd_chk("R10 level set", 12'h414, 8'h08);
        wr(12'h41C, 32'h08);
        rd_chk("R10 level persists", 12'h414, 8'h08);

        // R11 mask and interrupt line
        wr(12'h410, 32'h08);
        rd_chk("R11 masked", 12'h418, 8'h08);
        check("R11 irq high", {7'd0, irq}, 8'h01);
        pin_in = 8'h02; settle();
        wr(12'h41C, 32'hFF);
        rd_chk("R10 cleared", 12'h414, 8'h00);
        check("R11 irq low", {7'd0, irq}, 8'h00);
        pin_in = 8'h03; settle();   // bit0 rising, not masked
        rd_chk("R11 raw unmasked", 12'h414, 8'h01);
        rd_chk("R11 masked zero", 12'h418, 8'h00);
        check("R11 irq stays low", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule